// File: doc/BRIEF.md
# Power Domain Shutdown and Wake Sequencer

This block drives the three control lines of one switchable power domain: a retention line, an isolation enable and a power switch enable. On a shutdown request it raises them one per clock cycle in a fixed order: retention, then isolation, then the switch. It then waits for the domain to acknowledge. On a wake request it releases them in the reverse order. The switch opens first, and the controller waits for the power-up acknowledge. Retention then falls, which reloads the live registers. Isolation is removed last. Each acknowledge wait is bounded by a cycle limit. When the limit expires, a sticky timeout error is raised and the sequence goes on.

States, all with 4-space indent in the RTL:

| State | Controls |
|---|---|
| `ST_ON` | none |
| `ST_SAVE` | retention |
| `ST_ISO` | retention, isolation |
| `ST_SW_OFF` | all three, waiting for the power-down acknowledge |
| `ST_OFF` | all three |
| `ST_PWR_UP` | retention and isolation, switch released, waiting for the power-up acknowledge |
| `ST_RESTORE` | isolation only |

Transitions:

- `ST_ON` goes to `ST_SAVE` on a shutdown request.
- `ST_SAVE` goes to `ST_ISO` unconditionally.
- `ST_ISO` goes to `ST_SW_OFF` unconditionally.
- `ST_SW_OFF` goes to `ST_OFF` on the acknowledge or on expiry of the limit.
- `ST_OFF` goes to `ST_PWR_UP` on a wake request or on a held wake.
- `ST_PWR_UP` goes to `ST_RESTORE` on the acknowledge or on expiry of the limit.
- `ST_RESTORE` goes to `ST_ON` unconditionally.

Two behavioural shells sit next to the controller. The first is a retention register with an always-on shadow copy. The second is a per-bit isolation clamp on the domain output. Together they show that register state survives a full shutdown.

Top module: `pgate_seq_top`

## Requirements
- R1: After reset the three control lines are low, the status reads ON (2'b00), the timeout error is low and the domain output is 0.
- R2: A shutdown request sampled in `ST_ON` raises retention one cycle later. Isolation rises the next cycle with retention still high. The switch enable rises the cycle after that with both others still high.
- R3: Status reads TRANS (2'b10) during every transitional state. After the power-down acknowledge it reads OFF (2'b01) with all three lines high.
- R4: If no acknowledge is seen during TIMEOUT cycles of a wait state, the timeout error rises and stays high until reset. The controller then advances as if the acknowledge had come.
- R5: On wake the switch enable falls first while retention and isolation stay high. After the power-up acknowledge, retention falls while isolation stays high. Isolation falls on the next cycle.
- R6: A wake request that arrives while the shutdown sequence is running is held. Wake-up then starts on the cycle after `ST_OFF` is reached.
- R7: While isolation is high, bit i of the domain output equals bit i of CLAMP_MASK, whatever the live register holds.
- R8: The live register value present when retention rose is on the domain output on the cycle that isolation falls after wake.
- R9: A load into the live register takes effect only while retention and isolation are both low. Loads at other times are ignored.
- R10: A shutdown request in `ST_OFF` has no effect, and neither does a wake request in `ST_ON`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Shutdown request |
| wake_req | input | 1 | Wake request |
| dom_ack | input | 1 | Acknowledge from the switched domain (power-down or power-up) |
| dom_load | input | 1 | Write enable for the domain live register |
| dom_din | input | W | Data for the domain live register |
| ret_save | output | 1 | Retention control: rise saves, fall restores |
| iso_en | output | 1 | Isolation enable |
| sw_off | output | 1 | Power switch enable (1 = domain unpowered) |
| pwr_stat | output | 2 | 00 ON, 01 OFF, 10 TRANS |
| ack_timeout | output | 1 | Sticky acknowledge-timeout error |
| dom_q | output | W | Isolated domain output |

## Verification
The bench builds the block with W = 8, TIMEOUT = 4 and CLAMP_MASK = 8'h0F. A short limit makes an expired acknowledge wait appear after only a few idle cycles, both in power-down and in power-up. The mixed clamp mask shows that each bit is clamped to its own value. The data values 8'h3C and 8'h5A differ from the clamp and from the cleared power-off state. This lets a lost, blocked or wrongly restored value be seen on the output.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    typedef enum logic [2:0] {
        ST_ON      = 3'd0,
        ST_SAVE    = 3'd1,
        ST_ISO     = 3'd2,
        ST_SW_OFF  = 3'd3,
        ST_OFF     = 3'd4,
        ST_PWR_UP  = 3'd5,
        ST_RESTORE = 3'd6
    } pg_state_e;

    typedef enum logic [1:0] {
        PS_ON    = 2'b00,
        PS_OFF   = 2'b01,
        PS_TRANS = 2'b10
    } pg_stat_e;

    typedef struct packed {
        logic ret;
        logic iso;
        logic sw;
    } pg_ctl_t;

endpackage

// File: rtl/pgate_ack_timer.sv
module pgate_ack_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && !ack && (cnt_q == LAST);

    // R4: the counter never passes the limit while waiting
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> cnt_q <= LAST);
endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm
    import pgate_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_req,
    input  logic     wake_req,
    input  logic     dom_ack,
    output pg_ctl_t  ctl,
    output pg_stat_e stat,
    output logic     err
);
    pg_state_e state_q, state_d;
    logic      wake_pend_q;
    logic      err_q;
    logic      waiting;
    logic      expired;

    assign waiting = (state_q == ST_SW_OFF) || (state_q == ST_PWR_UP);

    pgate_ack_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .ack     (dom_ack),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:      if (sleep_req) state_d = ST_SAVE;
            ST_SAVE:    state_d = ST_ISO;
            ST_ISO:     state_d = ST_SW_OFF;
            ST_SW_OFF:  if (dom_ack || expired) state_d = ST_OFF;
            ST_OFF:     if (wake_req || wake_pend_q) state_d = ST_PWR_UP;
            ST_PWR_UP:  if (dom_ack || expired) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_ON;
            default:    state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_ON;
            wake_pend_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (expired) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_OFF) begin
                wake_pend_q <= 1'b0;
            end else if (wake_req && (state_q == ST_SAVE || state_q == ST_ISO ||
                                      state_q == ST_SW_OFF)) begin
                wake_pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl  = '0;
        stat = PS_TRANS;
        unique case (state_q)
            ST_ON:      stat = PS_ON;
            ST_SAVE:    ctl  = '{ret: 1'b1, iso: 1'b0, sw: 1'b0};
            ST_ISO:     ctl  = '{ret: 1'b1, iso: 1'b1, sw: 1'b0};
            ST_SW_OFF:  ctl  = '{ret: 1'b1, iso: 1'b1, sw: 1'b1};
            ST_OFF: begin
                ctl  = '{ret: 1'b1, iso: 1'b1, sw: 1'b1};
                stat = PS_OFF;
            end
            ST_PWR_UP:  ctl  = '{ret: 1'b1, iso: 1'b1, sw: 1'b0};
            ST_RESTORE: ctl  = '{ret: 1'b0, iso: 1'b1, sw: 1'b0};
            default:    ctl  = '0;
        endcase
    end

    assign err = err_q;

    // R2: the switch is only ever closed with retention and isolation both held
    p_sw_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sw |-> ctl.ret && ctl.iso);
    // R2: isolation rises only after retention was already high
    p_iso_after_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.iso) |-> $past(ctl.ret));
    // R2: the switch rises only after isolation was already high
    p_sw_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.sw) |-> $past(ctl.iso));
    // R5: restore happens with the switch open and isolation still on
    p_restore_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.ret) |-> ctl.iso && !ctl.sw && !$past(ctl.sw));
    // R5: isolation is the last line to be released
    p_uniso_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.iso) |-> !ctl.ret && !$past(ctl.ret));
    // R4: the error is sticky
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R4: the error only rises out of an acknowledge wait
    p_err_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(waiting));
    // R3: OFF status always comes with all three lines high
    p_off_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat == PS_OFF |-> ctl.ret && ctl.iso && ctl.sw);
endmodule

// File: rtl/pgate_retain.sv
module pgate_retain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ret,
    input  logic         iso,
    input  logic         sw,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] live
);
    logic [W-1:0] live_q;
    logic [W-1:0] shadow_q;
    logic         ret_d;
    logic         save_ev;
    logic         restore_ev;

    assign save_ev    = ret && !ret_d;
    assign restore_ev = !ret && ret_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_d    <= 1'b0;
            shadow_q <= '0;
        end else begin
            ret_d <= ret;
            if (save_ev) begin
                shadow_q <= live_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (sw) begin
            live_q <= '0;
        end else if (restore_ev) begin
            live_q <= shadow_q;
        end else if (load && !ret && !iso) begin
            live_q <= din;
        end
    end

    assign live = live_q;

    // R9: the live register does not change while isolation is high unless restoring
    p_no_load_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(iso) && !$past(sw) && !$past(restore_ev) |-> $stable(live_q));
endmodule

// File: rtl/pgate_iso_clamp.sv
module pgate_iso_clamp #(
    parameter int         W          = 16,
    parameter logic [W-1:0] CLAMP_MASK = '0
) (
    input  logic         iso,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = iso ? CLAMP_MASK[i] : din[i];
    end
endmodule

// File: rtl/pgate_seq_top.sv
module pgate_seq_top
    import pgate_pkg::*;
#(
    parameter int           W          = 16,
    parameter int           TIMEOUT    = 64,
    parameter logic [W-1:0] CLAMP_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_req,
    input  logic         wake_req,
    input  logic         dom_ack,
    input  logic         dom_load,
    input  logic [W-1:0] dom_din,
    output logic         ret_save,
    output logic         iso_en,
    output logic         sw_off,
    output logic [1:0]   pwr_stat,
    output logic         ack_timeout,
    output logic [W-1:0] dom_q
);
    pg_ctl_t      ctl;
    pg_stat_e     stat;
    logic [W-1:0] live;

    pgate_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .dom_ack   (dom_ack),
        .ctl       (ctl),
        .stat      (stat),
        .err       (ack_timeout)
    );

    pgate_retain #(.W(W)) u_retain (
        .clk   (clk),
        .rst_n (rst_n),
        .ret   (ctl.ret),
        .iso   (ctl.iso),
        .sw    (ctl.sw),
        .load  (dom_load),
        .din   (dom_din),
        .live  (live)
    );

    pgate_iso_clamp #(.W(W), .CLAMP_MASK(CLAMP_MASK)) u_clamp (
        .iso  (ctl.iso),
        .din  (live),
        .dout (dom_q)
    );

    assign ret_save = ctl.ret;
    assign iso_en   = ctl.iso;
    assign sw_off   = ctl.sw;
    assign pwr_stat = stat;

    // R7: the output is the clamp pattern whenever isolation is on
    p_clamp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> dom_q == CLAMP_MASK);
endmodule

// File: tb/pgate_seq_top_bench.sv
module pgate_seq_top_bench;
    localparam int         W    = 8;
    localparam int         TO   = 4;
    localparam logic [7:0] CLMP = 8'h0F;
    localparam logic [1:0] S_ON = 2'b00, S_OFF = 2'b01, S_TR = 2'b10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_req = 1'b0, wake_req = 1'b0, dom_ack = 1'b0, dom_load = 1'b0;
    logic [W-1:0] dom_din = '0;
    logic         ret_save, iso_en, sw_off, ack_timeout;
    logic [1:0]   pwr_stat;
    logic [W-1:0] dom_q;

    pgate_seq_top #(.W(W), .TIMEOUT(TO), .CLAMP_MASK(CLMP)) u_pgate_seq_top (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .dom_ack(dom_ack), .dom_load(dom_load), .dom_din(dom_din),
        .ret_save(ret_save), .iso_en(iso_en), .sw_off(sw_off),
        .pwr_stat(pwr_stat), .ack_timeout(ack_timeout), .dom_q(dom_q)
    );

    always #4 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [2:0] ctl;
        logic [1:0] st;
        logic       err;
        logic [7:0] q;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    exp_item_t it;
    int        cyc = 0;
    int        checks = 0;
    int        fails = 0;
    bit        done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int cy, logic [2:0] c, logic [1:0] s, logic e,
                                 logic [7:0] qv, string t);
        exp_item_t x;
        x.cyc = cy; x.ctl = c; x.st = s; x.err = e; x.q = qv; x.tag = t;
        exp_q.push_back(x);
    endfunction

    // monitor: pop expected items when their cycle comes up
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            it = exp_q.pop_front();
            checks++;
            if (it.cyc != cyc ||
                {ret_save, iso_en, sw_off} != it.ctl || pwr_stat != it.st ||
                ack_timeout != it.err || dom_q != it.q) begin
                fails++;
                $display("FAIL %s cyc %0d: actual ctl=%b st=%b err=%b q=%h expected ctl=%b st=%b err=%b q=%h",
                         it.tag, cyc, {ret_save, iso_en, sw_off}, pwr_stat, ack_timeout,
                         dom_q, it.ctl, it.st, it.err, it.q);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        int c;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        push(cyc + 1, 3'b000, S_ON, 1'b0, 8'h00, "R1");
        step();
        // R9 load while fully on
        dom_load = 1'b1; dom_din = 8'h3C;
        push(cyc + 1, 3'b000, S_ON, 1'b0, 8'h3C, "R9");
        step();
        dom_load = 1'b0;

        // R2/R3/R7 shutdown with ack
        c = cyc;
        sleep_req = 1'b1;
        push(c + 1, 3'b100, S_TR, 1'b0, 8'h3C, "R2");
        push(c + 2, 3'b110, S_TR, 1'b0, CLMP, "R7");
        push(c + 3, 3'b111, S_TR, 1'b0, CLMP, "R2");
        push(c + 4, 3'b111, S_OFF, 1'b0, CLMP, "R3");
        step();
        sleep_req = 1'b0;
        dom_load = 1'b1; dom_din = 8'hFF;   // R9: blocked during save
        step();
        dom_load = 1'b0;
        step();
        dom_ack = 1'b1;
        step();
        dom_ack = 1'b0;
        sleep_req = 1'b1;                    // R10: ignored while off
        push(cyc + 1, 3'b111, S_OFF, 1'b0, CLMP, "R10");
        step();
        sleep_req = 1'b0;

        // R5/R8 wake
        c = cyc;
        wake_req = 1'b1;
        push(c + 1, 3'b110, S_TR, 1'b0, CLMP, "R5");
        push(c + 2, 3'b010, S_TR, 1'b0, CLMP, "R5");
        push(c + 3, 3'b000, S_ON, 1'b0, 8'h3C, "R8");
        step();
        wake_req = 1'b0;
        dom_ack = 1'b1;
        step();
        dom_ack = 1'b0;
        step();
        // R10 wake while on
        wake_req = 1'b1;
        push(cyc + 1, 3'b000, S_ON, 1'b0, 8'h3C, "R10");
        step();
        wake_req = 1'b0;
        dom_load = 1'b1; dom_din = 8'h5A;
        push(cyc + 1, 3'b000, S_ON, 1'b0, 8'h5A, "R9");
        step();
        dom_load = 1'b0;

        // R6 wake held during shutdown
        c = cyc;
        sleep_req = 1'b1;
        push(c + 1, 3'b100, S_TR, 1'b0, 8'h5A, "R2");
        push(c + 2, 3'b110, S_TR, 1'b0, CLMP, "R2");
        push(c + 3, 3'b111, S_TR, 1'b0, CLMP, "R2");
        push(c + 4, 3'b111, S_OFF, 1'b0, CLMP, "R3");
        push(c + 5, 3'b110, S_TR, 1'b0, CLMP, "R6");
        push(c + 6, 3'b010, S_TR, 1'b0, CLMP, "R5");
        push(c + 7, 3'b000, S_ON, 1'b0, 8'h5A, "R8");
        step();
        sleep_req = 1'b0;
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        step();
        dom_ack = 1'b1;
        step();
        dom_ack = 1'b0;
        step();
        dom_ack = 1'b1;
        step();
        dom_ack = 1'b0;
        step();

        // R4 timeout on power-down, then on power-up
        c = cyc;
        sleep_req = 1'b1;
        push(c + 3, 3'b111, S_TR, 1'b0, CLMP, "R4");
        push(c + 3 + TO - 1, 3'b111, S_TR, 1'b0, CLMP, "R4");
        push(c + 3 + TO, 3'b111, S_OFF, 1'b1, CLMP, "R4");
        step();
        sleep_req = 1'b0;
        repeat (TO + 3) step();
        c = cyc;
        wake_req = 1'b1;
        push(c + 1, 3'b110, S_TR, 1'b1, CLMP, "R4");
        push(c + 1 + TO, 3'b010, S_TR, 1'b1, CLMP, "R4");
        push(c + 2 + TO, 3'b000, S_ON, 1'b1, 8'h5A, "R8");
        step();
        wake_req = 1'b0;
        repeat (TO + 4) step();

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        report();
    end
endmodule